// File: doc/BRIEF.md
# Shared-Link Frame Tag Decoder

This block sits behind the deserializer of a serial audio link that carries one master codec and up to three slave codecs. When a frame has been shifted in, the deserializer pulses `frame_strobe` for one cycle and presents the 16-bit tag slot, the 20-bit command address slot and the 20-bit command data slot. The block works out whether the frame counts at all, whether this codec is the one being addressed, and what kind of register access was asked for. It then issues single-cycle read or write strobes with the register address and the write data, and it publishes which of the ten data slots carry valid samples.

The codec's own identity comes from two active-low strap pins. Left open, both pins read high and the codec resolves to ID 00, the master, which drives the link bit clock. Any other ID makes the codec a slave, which receives the bit clock. The master qualifies commands with the two command tag bits. A slave ignores those bits and treats a match between the tag's ID field and its own nonzero ID as the sign that the command is valid.

Top module: `slot0_tag_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rd_stb`, `wr_stb`, `slot_valid`, `reg_addr` and `wr_data` are all zero, `codec_id` is 00 and `is_master` is 1.
- R2: `codec_id` equals the bitwise inverse of `id_strap_n`, one clock after the pins are sampled. `is_master` (the bit-clock output enable) is 1 exactly when that ID is 00.
- R3: A presented frame whose tag bit 15 (frame valid) is 0 produces no strobe, whatever its ID field holds, and clears `slot_valid` to zero.
- R4: On a valid frame, `slot_valid[k]` takes tag bit k+3, so bit 0 stands for slot 3 and bit 9 for slot 12. It is held until the next presented frame.
- R5: A master (ID 00) raises `rd_stb` when tag bit 14 is 1, the tag ID field (bits 1..0) is 00 and command address bit 19 is 1. `reg_addr` then carries command address bits 18..12.
- R6: A master raises `wr_stb` only when tag bits 14 and 13 are both 1, the ID field is 00 and command address bit 19 is 0. `wr_data` then carries command data bits 19..4.
- R7: A slave (ID 01, 10 or 11) ignores tag bits 14 and 13. It treats a tag ID field equal to its own ID as both address-valid and data-valid, and then reads or writes following bit 19 of the command address as in R5 and R6.
- R8: A tag ID field that differs from the codec's own ID produces no strobe, including a nonzero field seen by the master.
- R9: `rd_stb` and `wr_stb` are never high together, and each is high for exactly one cycle per accepted frame.
- R10: Outputs change only on the clock edge that samples `frame_strobe` high. Inputs presented while `frame_strobe` is low cause no strobe and leave `slot_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_strap_n | input | 2 | Active-low ID strap pins |
| frame_strobe | input | 1 | One-cycle pulse: the slot inputs hold a complete frame |
| tag_in | input | 16 | Tag slot of the frame |
| cmd_addr_slot | input | 20 | Command address slot |
| cmd_data_slot | input | 20 | Command data slot |
| codec_id | output | 2 | Resolved codec ID |
| is_master | output | 1 | High for ID 00; enables the bit-clock output driver |
| rd_stb | output | 1 | Register read strobe |
| wr_stb | output | 1 | Register write strobe |
| reg_addr | output | 7 | Register address of the last access |
| wr_data | output | 16 | Write data of the last write |
| slot_valid | output | 10 | Valid flags for slots 3 to 12 |

## Verification
Every result is one register stage behind its stimulus. Strobes, address, data and slot flags appear on the edge that samples `frame_strobe`, and `codec_id` and `is_master` appear on the edge after the straps change. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the capturing edge. It then checks one cycle later that the strobes have dropped. Before any frame after a strap change it lets two edges pass, so the decode always sees the settled ID.

// File: rtl/tagdec_pkg.sv
package tagdec_pkg;

    localparam int TAG_W     = 16;
    localparam int ID_W      = 2;
    localparam int NUM_DSLOT = 10;

    // Bit order follows the tag slot layout, MSB first.
    typedef struct packed {
        logic                 frame_ok;
        logic                 addr_tag;
        logic                 data_tag;
        logic [NUM_DSLOT-1:0] slot_flags;
        logic                 rsvd;
        logic [ID_W-1:0]      id_field;
    } tag_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } cmd_kind_t;

    function automatic logic is_slave_id(input logic [ID_W-1:0] id);
        return id != '0;
    endfunction

endpackage

// File: rtl/id_strap_resolver.sv
module id_strap_resolver
    import tagdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ID_W-1:0] strap_n,
    output logic [ID_W-1:0] codec_id,
    output logic            is_master
);

    always_ff @(posedge clk) begin
        if (rst) begin
            codec_id  <= '0;
            is_master <= 1'b1;
        end else begin
            codec_id  <= ~strap_n;
            is_master <= &strap_n;
        end
    end

    p_master_tracks_id_r2: assert property (@(posedge clk) disable iff (rst)
        is_master == (codec_id == '0));

    p_id_follows_straps_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> codec_id == ~$past(strap_n));

endmodule

// File: rtl/tag_field_decoder.sv
module tag_field_decoder
    import tagdec_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              frame_strobe,
    input  tag_t              tag,
    input  logic [SLOT_W-1:0] addr_slot,
    input  logic [SLOT_W-1:0] data_slot,
    input  logic [ID_W-1:0]   own_id,
    output logic              frame_take,
    output cmd_kind_t         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int RW_BIT   = SLOT_W - 1;
    localparam int ADDR_TOP = SLOT_W - 2;
    localparam int DATA_TOP = SLOT_W - 1;

    logic id_hit;
    logic addr_ok;
    logic data_ok;
    logic rd_flag;

    always_comb begin
        frame_take = frame_strobe & tag.frame_ok;
        id_hit     = (tag.id_field == own_id);
        if (is_slave_id(own_id)) begin
            addr_ok = id_hit;
            data_ok = id_hit;
        end else begin
            addr_ok = id_hit & tag.addr_tag;
            data_ok = id_hit & tag.data_tag;
        end
        rd_flag = addr_slot[RW_BIT];
        kind.rd = frame_take & addr_ok & rd_flag;
        kind.wr = frame_take & addr_ok & data_ok & ~rd_flag;
        addr    = addr_slot[ADDR_TOP -: ADDR_W];
        data    = data_slot[DATA_TOP -: DATA_W];
    end

endmodule

// File: rtl/access_strobe_gen.sv
module access_strobe_gen
    import tagdec_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_strobe,
    input  logic                 frame_take,
    input  cmd_kind_t            kind,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [DATA_W-1:0]    data_in,
    input  logic [NUM_DSLOT-1:0] flags_in,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic [NUM_DSLOT-1:0] slot_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_stb     <= 1'b0;
            wr_stb     <= 1'b0;
            reg_addr   <= '0;
            wr_data    <= '0;
            slot_valid <= '0;
        end else begin
            rd_stb <= kind.rd;
            wr_stb <= kind.wr;
            if (kind.rd || kind.wr) begin
                reg_addr <= addr_in;
            end
            if (kind.wr) begin
                wr_data <= data_in;
            end
            if (frame_strobe) begin
                slot_valid <= frame_take ? flags_in : '0;
            end
        end
    end

    p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |=> !(rd_stb || wr_stb) || $past(frame_strobe));

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(frame_strobe) |-> $stable(slot_valid));

endmodule

// File: rtl/slot0_tag_decoder.sv
module slot0_tag_decoder
    import tagdec_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           id_strap_n,
    input  logic                 frame_strobe,
    input  logic [15:0]          tag_in,
    input  logic [SLOT_W-1:0]    cmd_addr_slot,
    input  logic [SLOT_W-1:0]    cmd_data_slot,
    output logic [1:0]           codec_id,
    output logic                 is_master,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic [9:0]           slot_valid
);

    tag_t                  tag_s;
    logic                  frame_take;
    cmd_kind_t             kind;
    logic [ADDR_W-1:0]     dec_addr;
    logic [DATA_W-1:0]     dec_data;

    assign tag_s = tag_t'(tag_in);

    id_strap_resolver u_ids (
        .clk       (clk),
        .rst       (rst),
        .strap_n   (id_strap_n),
        .codec_id  (codec_id),
        .is_master (is_master)
    );

    tag_field_decoder #(
        .SLOT_W (SLOT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .frame_strobe (frame_strobe),
        .tag          (tag_s),
        .addr_slot    (cmd_addr_slot),
        .data_slot    (cmd_data_slot),
        .own_id       (codec_id),
        .frame_take   (frame_take),
        .kind         (kind),
        .addr         (dec_addr),
        .data         (dec_data)
    );

    access_strobe_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_stb (
        .clk          (clk),
        .rst          (rst),
        .frame_strobe (frame_strobe),
        .frame_take   (frame_take),
        .kind         (kind),
        .addr_in      (dec_addr),
        .data_in      (dec_data),
        .flags_in     (tag_s.slot_flags),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .reg_addr     (reg_addr),
        .wr_data      (wr_data),
        .slot_valid   (slot_valid)
    );

    p_invalid_frame_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> $past(tag_in[15]) && $past(frame_strobe));

    p_master_write_tags_r6: assert property (@(posedge clk) disable iff (rst)
        wr_stb && $past(is_master) |-> $past(tag_in[14]) && $past(tag_in[13]));

    p_write_flag_low_r6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !$past(cmd_addr_slot[SLOT_W-1]));

    p_id_field_match_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> $past(tag_in[1:0]) == $past(codec_id));

endmodule

// File: tb/sim_slot0_tag_decoder.sv
module sim_slot0_tag_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  id_strap_n;
    logic        frame_strobe;
    logic [15:0] tag_in;
    logic [19:0] cmd_addr_slot;
    logic [19:0] cmd_data_slot;
    logic [1:0]  codec_id;
    logic        is_master;
    logic        rd_stb;
    logic        wr_stb;
    logic [6:0]  reg_addr;
    logic [15:0] wr_data;
    logic [9:0]  slot_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    slot0_tag_decoder u0 (
        .clk           (clk),
        .rst           (rst),
        .id_strap_n    (id_strap_n),
        .frame_strobe  (frame_strobe),
        .tag_in        (tag_in),
        .cmd_addr_slot (cmd_addr_slot),
        .cmd_data_slot (cmd_data_slot),
        .codec_id      (codec_id),
        .is_master     (is_master),
        .rd_stb        (rd_stb),
        .wr_stb        (wr_stb),
        .reg_addr      (reg_addr),
        .wr_data       (wr_data),
        .slot_valid    (slot_valid)
    );

    function automatic logic [15:0] mk_tag(input logic fv, input logic ca, input logic cd,
                                           input logic [9:0] sv, input logic [1:0] id);
        return {fv, ca, cd, sv, 1'b0, id};
    endfunction

    function automatic logic [19:0] mk_s1(input logic rd, input logic [6:0] a);
        return {rd, a, 12'h000};
    endfunction

    function automatic logic [19:0] mk_s2(input logic [15:0] d);
        return {d, 4'h0};
    endfunction

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  strap_n;
        logic [15:0] tag;
        logic [19:0] s1;
        logic [19:0] s2;
        logic        e_rd;
        logic        e_wr;
        logic [6:0]  e_addr;
        logic [15:0] e_data;
        logic [9:0]  e_sv;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd5, 2'b11, mk_tag(1,1,0,10'h003,2'd0), mk_s1(1,7'h26), mk_s2(16'h0000), 1'b1, 1'b0, 7'h26, 16'h0000, 10'h003},
        '{4'd6, 2'b11, mk_tag(1,1,1,10'h001,2'd0), mk_s1(0,7'h02), mk_s2(16'hA5C3), 1'b0, 1'b1, 7'h02, 16'hA5C3, 10'h001},
        '{4'd6, 2'b11, mk_tag(1,1,0,10'h3FF,2'd0), mk_s1(0,7'h11), mk_s2(16'h5555), 1'b0, 1'b0, 7'h00, 16'h0000, 10'h3FF},
        '{4'd8, 2'b11, mk_tag(1,1,1,10'h000,2'd2), mk_s1(0,7'h12), mk_s2(16'h6666), 1'b0, 1'b0, 7'h00, 16'h0000, 10'h000},
        '{4'd3, 2'b11, mk_tag(0,1,1,10'h3FF,2'd0), mk_s1(0,7'h13), mk_s2(16'h7777), 1'b0, 1'b0, 7'h00, 16'h0000, 10'h000},
        '{4'd7, 2'b10, mk_tag(1,0,0,10'h000,2'd1), mk_s1(0,7'h38), mk_s2(16'h1234), 1'b0, 1'b1, 7'h38, 16'h1234, 10'h000},
        '{4'd8, 2'b10, mk_tag(1,1,1,10'h000,2'd0), mk_s1(0,7'h14), mk_s2(16'h8888), 1'b0, 1'b0, 7'h00, 16'h0000, 10'h000},
        '{4'd7, 2'b01, mk_tag(1,0,0,10'h200,2'd2), mk_s1(1,7'h7C), mk_s2(16'h0000), 1'b1, 1'b0, 7'h7C, 16'h0000, 10'h200},
        '{4'd8, 2'b00, mk_tag(1,0,0,10'h0F0,2'd2), mk_s1(1,7'h15), mk_s2(16'h0000), 1'b0, 1'b0, 7'h00, 16'h0000, 10'h0F0},
        '{4'd3, 2'b00, mk_tag(0,0,0,10'h155,2'd3), mk_s1(0,7'h16), mk_s2(16'h9999), 1'b0, 1'b0, 7'h00, 16'h0000, 10'h000},
        '{4'd7, 2'b00, mk_tag(1,1,0,10'h2AA,2'd3), mk_s1(0,7'h7F), mk_s2(16'hFFFF), 1'b0, 1'b1, 7'h7F, 16'hFFFF, 10'h2AA}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd3:    return "R3";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cycles);
            finish_run();
        end
    end

    task automatic present(input logic [15:0] t, input logic [19:0] a, input logic [19:0] d);
        frame_strobe  = 1'b1;
        tag_in        = t;
        cmd_addr_slot = a;
        cmd_data_slot = d;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    initial begin
        rst           = 1'b1;
        id_strap_n    = 2'b11;
        frame_strobe  = 1'b0;
        tag_in        = '0;
        cmd_addr_slot = '0;
        cmd_data_slot = '0;
        repeat (3) @(negedge clk);

        // R1: state under reset
        chk(!rd_stb && !wr_stb, "R1", "strobes in reset", {rd_stb, wr_stb}, 0);
        chk(slot_valid == 0, "R1", "slot_valid in reset", slot_valid, 0);
        chk(reg_addr == 0 && wr_data == 0, "R1", "addr/data in reset", {reg_addr, wr_data}, 0);
        chk(codec_id == 0 && is_master, "R1", "id/master in reset", {codec_id, is_master}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_stb && !wr_stb && slot_valid == 0, "R1", "first cycle out of reset",
            {rd_stb, wr_stb, slot_valid}, 0);

        // Table walk: R3 R5 R6 R7 R8, plus R2 and R9 on every vector
        for (int i = 0; i < NV; i++) begin
            id_strap_n = VECS[i].strap_n;
            repeat (2) @(negedge clk);
            chk(codec_id == ~VECS[i].strap_n, "R2", "codec_id", codec_id, ~VECS[i].strap_n);
            chk(is_master == (VECS[i].strap_n == 2'b11), "R2", "is_master", is_master,
                VECS[i].strap_n == 2'b11);
            present(VECS[i].tag, VECS[i].s1, VECS[i].s2);
            chk(rd_stb == VECS[i].e_rd, req_name(VECS[i].req), "rd_stb", rd_stb, VECS[i].e_rd);
            chk(wr_stb == VECS[i].e_wr, req_name(VECS[i].req), "wr_stb", wr_stb, VECS[i].e_wr);
            if (VECS[i].e_rd || VECS[i].e_wr)
                chk(reg_addr == VECS[i].e_addr, "R5", "reg_addr", reg_addr, VECS[i].e_addr);
            if (VECS[i].e_wr)
                chk(wr_data == VECS[i].e_data, "R6", "wr_data", wr_data, VECS[i].e_data);
            chk(slot_valid == VECS[i].e_sv, "R4", "slot_valid", slot_valid, VECS[i].e_sv);
            @(negedge clk);
            chk(!rd_stb && !wr_stb, "R9", "strobe drops after one cycle", {rd_stb, wr_stb}, 0);
        end

        // R10: frame-shaped inputs without frame_strobe
        id_strap_n = 2'b11;
        repeat (2) @(negedge clk);
        present(mk_tag(1,1,1,10'h0C3,2'd0), mk_s1(0,7'h05), mk_s2(16'hBEEF));
        chk(wr_stb && wr_data == 16'hBEEF, "R6", "master write before hold test",
            {wr_stb, wr_data}, {1'b1, 16'hBEEF});
        frame_strobe  = 1'b0;
        tag_in        = mk_tag(1,1,1,10'h3FF,2'd0);
        cmd_addr_slot = mk_s1(1,7'h44);
        repeat (2) @(negedge clk);
        chk(!rd_stb && !wr_stb, "R10", "no strobe without frame_strobe", {rd_stb, wr_stb}, 0);
        chk(slot_valid == 10'h0C3, "R10", "slot_valid held", slot_valid, 10'h0C3);
        chk(reg_addr == 7'h05, "R10", "reg_addr held", reg_addr, 7'h05);

        // R2: strap change lands one clock later
        id_strap_n = 2'b01;
        #1;
        chk(codec_id == 2'b00, "R2", "id before edge", codec_id, 0);
        @(negedge clk);
        chk(codec_id == 2'b10 && !is_master, "R2", "id one edge later", {codec_id, is_master}, 3'b100);

        // R9: back-to-back frames give one strobe each
        repeat (1) @(negedge clk);
        present(mk_tag(1,0,0,10'h000,2'd2), mk_s1(1,7'h21), mk_s2(16'h0));
        chk(rd_stb && !wr_stb && reg_addr == 7'h21, "R9", "first of two frames",
            {rd_stb, wr_stb, reg_addr}, {2'b10, 7'h21});
        frame_strobe  = 1'b1;
        tag_in        = mk_tag(1,0,0,10'h000,2'd2);
        cmd_addr_slot = mk_s1(0,7'h22);
        cmd_data_slot = mk_s2(16'h4321);
        @(negedge clk);
        frame_strobe = 1'b0;
        chk(!rd_stb && wr_stb && wr_data == 16'h4321, "R9", "second of two frames",
            {rd_stb, wr_stb, wr_data}, {2'b01, 16'h4321});
        @(negedge clk);
        chk(!rd_stb && !wr_stb, "R9", "quiet after pair", {rd_stb, wr_stb}, 0);

        finish_run();
    end

endmodule